// File: doc/BRIEF.md
# General-Purpose Register File with Data-Space Window

This block holds the 32 eight-bit working registers of a small microcontroller core. The ALU datapath reads two operands through two combinational read ports and writes its result through one byte write port. An instruction with an immediate operand carries only a 4-bit register field, so in immediate mode the block maps that field into the upper sixteen registers.

The six highest registers pair up into three 16-bit address pointers, called here A, B and C. Each pointer can be read or written as a whole word in one cycle. The register file also sits at the bottom of the data address space, so a load or store through a pointer can reach any register.

A data-space decoder sorts each load or store address into one of four regions: the register window, a reserved I/O window, the general SRAM range, or out of range. It steers SRAM traffic to an external SRAM port. It flags I/O and out-of-range accesses without touching any storage.

Top module: `gpr_file`

## Requirements
- R1: While `rst_n` is low, all 32 registers read as zero on every read path. Reset is asserted asynchronously and released synchronously to the clock.
- R2: A byte write (`wr_en`, `wr_idx`, `wr_data`) to any register is visible on both read ports from the next cycle on. Reads are combinational from the index inputs.
- R3: A read of a register that is being written in the same cycle returns the old value. There is no write-through bypass.
- R4: When `alu_imm` is 1, both the port A read and the byte write use register index 16 + the low 4 bits of the supplied index, so bit 4 of the index is ignored.
- R5: A data-space address from 0x0000 to 0x001F selects register n = address. `ds_rd_en` returns that register on `ds_rdata` combinationally. `ds_wr_en` writes `ds_wdata` into it at the next clock edge.
- R6: `ptr_sel` encodes 0 = pointer A (R27:R26), 1 = pointer B (R29:R28), 2 = pointer C (R31:R30). `ptr_rd_data` returns {odd register, even register}, with the low byte in the even register. `ptr_sel` = 3 reads zero.
- R7: `ptr_wr_en` writes both bytes of the selected pair at the same clock edge. With `ptr_sel` = 3 the write changes no register.
- R8: When several writers target the same register in one cycle, a pointer write beats both byte writers, and the ALU byte write beats a data-space store.
- R9: Addresses from 0x0060 to 0x0FFF go to the SRAM port. `sram_rd_en` and `sram_wr_en` follow the data-space enables, `sram_addr` equals the address, `sram_wdata` equals `ds_wdata`, and `ds_rdata` returns `sram_rdata`.
- R10: Addresses from 0x0020 to 0x005F raise `io_hit` while an access is enabled. Such an access changes no register, drives no SRAM strobe, and reads zero on `ds_rdata`.
- R11: Addresses above 0x0FFF raise `oor_flag` while an access is enabled. Such an access changes no register, drives no SRAM strobe, and reads zero on `ds_rdata`.
- R12: An ALU byte write, a data-space store and a pointer write that target different registers all take effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_imm | input | 1 | Immediate mode: map port A and write index into R16..R31 |
| rd_a_idx | input | 5 | Port A register index |
| rd_a_data | output | 8 | Port A read data |
| rd_b_idx | input | 5 | Port B register index |
| rd_b_data | output | 8 | Port B read data |
| wr_en | input | 1 | ALU byte write enable |
| wr_idx | input | 5 | ALU byte write index |
| wr_data | input | 8 | ALU byte write data |
| ptr_sel | input | 2 | Pointer select (0 A, 1 B, 2 C, 3 none) |
| ptr_rd_data | output | 16 | Selected pointer word |
| ptr_wr_en | input | 1 | Pointer word write enable |
| ptr_wr_data | input | 16 | Pointer word write data |
| ds_addr | input | 16 | Data-space address |
| ds_rd_en | input | 1 | Data-space load enable |
| ds_wr_en | input | 1 | Data-space store enable |
| ds_wdata | input | 8 | Data-space store data |
| ds_rdata | output | 8 | Data-space load data |
| sram_addr | output | 16 | SRAM address |
| sram_rd_en | output | 1 | SRAM read strobe |
| sram_wr_en | output | 1 | SRAM write strobe |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |
| io_hit | output | 1 | Access falls in the I/O window |
| oor_flag | output | 1 | Access is above the SRAM range |

## Verification
The results fall into two timing classes. Every read, region flag and SRAM strobe is combinational, so it is due in the same cycle as its stimulus. Every register update is due one edge later.

The bench drives inputs just after a falling edge and samples combinational results 1 ns later, before the rising edge. It samples register updates after the following falling edge, once the capturing rising edge has passed. The same-cycle sample is what shows the old value in the R3 check. Pointer, store and byte-write results are read back on the next cycle through the read ports, which the bench compares against its own shadow copy of all 32 registers.

// File: rtl/gpr_file_pkg.sv
package gpr_file_pkg;

  typedef enum logic [1:0] {
    RGN_REG  = 2'd0,
    RGN_IO   = 2'd1,
    RGN_SRAM = 2'd2,
    RGN_OOR  = 2'd3
  } ds_region_e;

  localparam int unsigned PTR_PAIRS = 3;

endpackage

// File: rtl/gpr_imm_map.sv
module gpr_imm_map #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             imm_mode,
  input  logic [IDX_W-1:0] raw_idx,
  output logic [IDX_W-1:0] eff_idx
);

  always_comb begin
    if (imm_mode) begin
      eff_idx = {1'b1, raw_idx[IDX_W-2:0]};
    end else begin
      eff_idx = raw_idx;
    end
  end

endmodule

// File: rtl/gpr_ds_decode.sv
module gpr_ds_decode
  import gpr_file_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned REG_TOP  = 31,
  parameter int unsigned IO_TOP   = 'h5F,
  parameter int unsigned SRAM_TOP = 'hFFF
) (
  input  logic [AW-1:0] addr,
  output ds_region_e    region
);

  localparam logic [AW-1:0] REG_TOP_A  = AW'(REG_TOP);
  localparam logic [AW-1:0] IO_TOP_A   = AW'(IO_TOP);
  localparam logic [AW-1:0] SRAM_TOP_A = AW'(SRAM_TOP);

  always_comb begin
    if (addr <= REG_TOP_A) begin
      region = RGN_REG;
    end else if (addr <= IO_TOP_A) begin
      region = RGN_IO;
    end else if (addr <= SRAM_TOP_A) begin
      region = RGN_SRAM;
    end else begin
      region = RGN_OOR;
    end
  end

endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DW       = 8,
  parameter int unsigned NPTR     = 3,
  parameter int unsigned PSW      = 2,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned PTR_BASE = NUM_REGS - 2 * NPTR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_we,
  input  logic [IDX_W-1:0] alu_idx,
  input  logic [DW-1:0]    alu_d,
  input  logic             st_we,
  input  logic [IDX_W-1:0] st_idx,
  input  logic [DW-1:0]    st_d,
  input  logic             ptr_we,
  input  logic [PSW-1:0]   ptr_sel,
  input  logic [2*DW-1:0]  ptr_d,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DW-1:0]    rd_a_q,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_b_q,
  input  logic [IDX_W-1:0] ds_idx,
  output logic [DW-1:0]    ds_q,
  output logic [2*DW-1:0]  ptr_q
);

  logic [NUM_REGS-1:0][DW-1:0] regs_w;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic          ptr_hit;
    logic [DW-1:0] ptr_byte;
    logic          alu_hit;
    logic          st_hit;
    logic          reg_en;
    logic [DW-1:0] reg_d;
    logic [DW-1:0] reg_q;

    if (i >= PTR_BASE) begin : g_pair
      localparam int unsigned PIDX = (i - PTR_BASE) / 2;
      localparam bit          HI   = ((i - PTR_BASE) % 2) == 1;
      assign ptr_hit  = ptr_we && (ptr_sel == PSW'(PIDX));
      assign ptr_byte = HI ? ptr_d[2*DW-1:DW] : ptr_d[DW-1:0];
    end else begin : g_plain
      assign ptr_hit  = 1'b0;
      assign ptr_byte = '0;
    end

    assign alu_hit = alu_we && (alu_idx == IDX_W'(i));
    assign st_hit  = st_we && (st_idx == IDX_W'(i));

    // next-state: pointer > ALU byte > data-space store
    always_comb begin
      reg_en = ptr_hit || alu_hit || st_hit;
      if (ptr_hit) begin
        reg_d = ptr_byte;
      end else if (alu_hit) begin
        reg_d = alu_d;
      end else if (st_hit) begin
        reg_d = st_d;
      end else begin
        reg_d = reg_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q <= '0;
      end else if (reg_en) begin
        reg_q <= reg_d;
      end
    end

    assign regs_w[i] = reg_q;
  end

  assign rd_a_q = regs_w[rd_a_idx];
  assign rd_b_q = regs_w[rd_b_idx];
  assign ds_q   = regs_w[ds_idx];

  always_comb begin
    ptr_q = '0;
    for (int p = 0; p < NPTR; p++) begin
      if (ptr_sel == PSW'(p)) begin
        ptr_q = {regs_w[PTR_BASE + 2*p + 1], regs_w[PTR_BASE + 2*p]};
      end
    end
  end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_file_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 16,
  parameter int unsigned IO_TOP   = 'h5F,
  parameter int unsigned SRAM_TOP = 'hFFF,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned PSW     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_imm,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [PSW-1:0]   ptr_sel,
  output logic [2*DW-1:0]  ptr_rd_data,
  input  logic             ptr_wr_en,
  input  logic [2*DW-1:0]  ptr_wr_data,
  input  logic [AW-1:0]    ds_addr,
  input  logic             ds_rd_en,
  input  logic             ds_wr_en,
  input  logic [DW-1:0]    ds_wdata,
  output logic [DW-1:0]    ds_rdata,
  output logic [AW-1:0]    sram_addr,
  output logic             sram_rd_en,
  output logic             sram_wr_en,
  output logic [DW-1:0]    sram_wdata,
  input  logic [DW-1:0]    sram_rdata,
  output logic             io_hit,
  output logic             oor_flag
);

  logic [IDX_W-1:0] eff_a_idx;
  logic [IDX_W-1:0] eff_wr_idx;
  ds_region_e       region;
  logic [DW-1:0]    ds_reg_q;
  logic             ds_any;
  logic             st_we;

  gpr_imm_map #(.IDX_W(IDX_W)) i_map_a (
    .imm_mode (alu_imm),
    .raw_idx  (rd_a_idx),
    .eff_idx  (eff_a_idx)
  );

  gpr_imm_map #(.IDX_W(IDX_W)) i_map_w (
    .imm_mode (alu_imm),
    .raw_idx  (wr_idx),
    .eff_idx  (eff_wr_idx)
  );

  gpr_ds_decode #(
    .AW       (AW),
    .REG_TOP  (NUM_REGS - 1),
    .IO_TOP   (IO_TOP),
    .SRAM_TOP (SRAM_TOP)
  ) i_dec (
    .addr   (ds_addr),
    .region (region)
  );

  assign ds_any = ds_rd_en || ds_wr_en;
  assign st_we  = ds_wr_en && (region == RGN_REG);

  gpr_storage #(
    .NUM_REGS (NUM_REGS),
    .DW       (DW),
    .NPTR     (PTR_PAIRS),
    .PSW      (PSW)
  ) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .alu_we   (wr_en),
    .alu_idx  (eff_wr_idx),
    .alu_d    (wr_data),
    .st_we    (st_we),
    .st_idx   (ds_addr[IDX_W-1:0]),
    .st_d     (ds_wdata),
    .ptr_we   (ptr_wr_en),
    .ptr_sel  (ptr_sel),
    .ptr_d    (ptr_wr_data),
    .rd_a_idx (eff_a_idx),
    .rd_a_q   (rd_a_data),
    .rd_b_idx (rd_b_idx),
    .rd_b_q   (rd_b_data),
    .ds_idx   (ds_addr[IDX_W-1:0]),
    .ds_q     (ds_reg_q),
    .ptr_q    (ptr_rd_data)
  );

  always_comb begin
    sram_addr  = ds_addr;
    sram_wdata = ds_wdata;
    sram_rd_en = ds_rd_en && (region == RGN_SRAM);
    sram_wr_en = ds_wr_en && (region == RGN_SRAM);
    io_hit     = ds_any && (region == RGN_IO);
    oor_flag   = ds_any && (region == RGN_OOR);
    ds_rdata   = '0;
    if (ds_rd_en) begin
      if (region == RGN_REG) begin
        ds_rdata = ds_reg_q;
      end else if (region == RGN_SRAM) begin
        ds_rdata = sram_rdata;
      end
    end
  end

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 16,
  parameter int unsigned IO_TOP   = 'h5F,
  parameter int unsigned SRAM_TOP = 'hFFF,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alu_imm,
  input logic [DW-1:0]    rd_a_data,
  input logic [IDX_W-1:0] rd_b_idx,
  input logic [DW-1:0]    rd_b_data,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DW-1:0]    wr_data,
  input logic [1:0]       ptr_sel,
  input logic [2*DW-1:0]  ptr_rd_data,
  input logic             ptr_wr_en,
  input logic [2*DW-1:0]  ptr_wr_data,
  input logic [AW-1:0]    ds_addr,
  input logic             ds_rd_en,
  input logic [DW-1:0]    ds_rdata,
  input logic [AW-1:0]    sram_addr,
  input logic             sram_rd_en,
  input logic             sram_wr_en,
  input logic [DW-1:0]    sram_rdata,
  input logic             io_hit,
  input logic             oor_flag
);

  localparam logic [IDX_W-1:0] C_LO = IDX_W'(NUM_REGS - 2);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (rd_a_data == '0 && rd_b_data == '0 && ptr_rd_data == '0)
        else $error("register not clear under reset");
    end
  end

  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !alu_imm && !ptr_wr_en && wr_idx == rd_b_idx) ##1 $stable(rd_b_idx)
    |-> rd_b_data == $past(wr_data));

  p_imm_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && alu_imm && !ptr_wr_en) ##1 (rd_b_idx == {1'b1, $past(wr_idx[IDX_W-2:0])})
    |-> rd_b_data == $past(wr_data));

  p_ptr_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr_en && ptr_sel != 2'd3) ##1 $stable(ptr_sel)
    |-> ptr_rd_data == $past(ptr_wr_data));

  p_ptr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr_en && ptr_sel == 2'd2 && wr_en && !alu_imm && wr_idx == C_LO) ##1 (rd_b_idx == C_LO)
    |-> rd_b_data == $past(ptr_wr_data[DW-1:0]));

  p_sram_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_rd_en && ds_addr > AW'(IO_TOP) && ds_addr <= AW'(SRAM_TOP))
    |-> (sram_rd_en && sram_addr == ds_addr && ds_rdata == sram_rdata));

  p_io_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (!sram_rd_en && !sram_wr_en && ds_rdata == '0 && !oor_flag));

  p_oor_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    oor_flag |-> (!sram_rd_en && !sram_wr_en && ds_rdata == '0 && !io_hit));

endmodule

bind gpr_file gpr_file_chk #(
  .NUM_REGS (NUM_REGS),
  .DW       (DW),
  .AW       (AW),
  .IO_TOP   (IO_TOP),
  .SRAM_TOP (SRAM_TOP)
) i_gpr_file_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alu_imm     (alu_imm),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .ptr_sel     (ptr_sel),
  .ptr_rd_data (ptr_rd_data),
  .ptr_wr_en   (ptr_wr_en),
  .ptr_wr_data (ptr_wr_data),
  .ds_addr     (ds_addr),
  .ds_rd_en    (ds_rd_en),
  .ds_rdata    (ds_rdata),
  .sram_addr   (sram_addr),
  .sram_rd_en  (sram_rd_en),
  .sram_wr_en  (sram_wr_en),
  .sram_rdata  (sram_rdata),
  .io_hit      (io_hit),
  .oor_flag    (oor_flag)
);

// File: tb/test_gpr_file.sv
`timescale 1ns/1ps
module test_gpr_file;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alu_imm;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [7:0]  rd_a_data, rd_b_data, wr_data;
  logic        wr_en;
  logic [1:0]  ptr_sel;
  logic [15:0] ptr_rd_data, ptr_wr_data;
  logic        ptr_wr_en;
  logic [15:0] ds_addr, sram_addr;
  logic        ds_rd_en, ds_wr_en;
  logic [7:0]  ds_wdata, ds_rdata, sram_wdata, sram_rdata;
  logic        sram_rd_en, sram_wr_en, io_hit, oor_flag;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [32];

  always #4 clk = ~clk;

  gpr_file i_gpr_file (
    .clk(clk), .rst_n(rst_n), .alu_imm(alu_imm),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_sel(ptr_sel), .ptr_rd_data(ptr_rd_data),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
    .ds_addr(ds_addr), .ds_rd_en(ds_rd_en), .ds_wr_en(ds_wr_en),
    .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
    .sram_addr(sram_addr), .sram_rd_en(sram_rd_en), .sram_wr_en(sram_wr_en),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .io_hit(io_hit), .oor_flag(oor_flag)
  );

  // {index, write data, expected readback}
  localparam logic [20:0] VEC [8] = '{
    {5'd0,  8'hA5, 8'hA5},
    {5'd31, 8'h3C, 8'h3C},
    {5'd15, 8'hFF, 8'hFF},
    {5'd16, 8'h01, 8'h01},
    {5'd7,  8'h80, 8'h80},
    {5'd26, 8'h5A, 8'h5A},
    {5'd12, 8'h00, 8'h00},
    {5'd19, 8'hC7, 8'hC7}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_imm = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    ptr_sel = 2'd3; ptr_wr_en = 0; ptr_wr_data = 0;
    ds_addr = 0; ds_rd_en = 0; ds_wr_en = 0; ds_wdata = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 32; i++) begin
      rd_b_idx = 5'(i);
      #1;
      chk(req, {8'h0, rd_b_data}, {8'h0, model[i]});
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); rd_a_idx = 0; rd_b_idx = 0; sram_rdata = 8'h00;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    step(); step();
    // R1: cleared during reset
    rd_a_idx = 5'd31; rd_b_idx = 5'd0; ptr_sel = 2'd2; #1;
    chk("R1", {8'h0, rd_a_data}, 16'h0);
    chk("R1", ptr_rd_data, 16'h0);
    step(); rst_n = 1; step();

    // R2: vector walk
    for (int v = 0; v < 8; v++) begin
      wr_en = 1; wr_idx = VEC[v][20:16]; wr_data = VEC[v][15:8];
      model[VEC[v][20:16]] = VEC[v][15:8];
      step(); idle();
      rd_a_idx = VEC[v][20:16]; rd_b_idx = VEC[v][20:16]; #1;
      chk("R2", {8'h0, rd_a_data}, {8'h0, VEC[v][7:0]});
      chk("R2", {8'h0, rd_b_data}, {8'h0, VEC[v][7:0]});
      step();
    end

    // R3: same-cycle read sees old value
    wr_en = 1; wr_idx = 5'd7; wr_data = 8'h22; rd_b_idx = 5'd7; rd_a_idx = 5'd7; #1;
    chk("R3", {8'h0, rd_b_data}, 16'h0080);
    chk("R3", {8'h0, rd_a_data}, 16'h0080);
    model[7] = 8'h22;
    step(); idle(); #1;
    chk("R3", {8'h0, rd_b_data}, 16'h0022);
    step();

    // R4: immediate mode maps to 16 + low 4 bits
    alu_imm = 1; wr_en = 1; wr_idx = 5'b00011; wr_data = 8'h5A;
    model[19] = 8'h5A;
    step(); idle();
    alu_imm = 1; rd_a_idx = 5'b00011; #1;
    chk("R4", {8'h0, rd_a_data}, 16'h005A);
    alu_imm = 0; #1;
    chk("R4", {8'h0, rd_a_data}, {8'h0, model[3]});
    step();

    // R5: data-space register window
    ds_wr_en = 1; ds_addr = 16'h0009; ds_wdata = 8'h77; model[9] = 8'h77;
    step(); idle();
    rd_b_idx = 5'd9; ds_rd_en = 1; ds_addr = 16'h001F; #1;
    chk("R5", {8'h0, rd_b_data}, 16'h0077);
    chk("R5", {8'h0, ds_rdata}, {8'h0, model[31]});
    chk("R5", {15'h0, sram_rd_en}, 16'h0);
    step(); idle();

    // R6/R7: pointer pairs
    ptr_wr_en = 1; ptr_sel = 2'd1; ptr_wr_data = 16'hBEEF;
    model[28] = 8'hEF; model[29] = 8'hBE;
    step(); idle();
    ptr_sel = 2'd1; #1;
    chk("R7", ptr_rd_data, 16'hBEEF);
    ptr_sel = 2'd0; #1;
    chk("R6", ptr_rd_data, {model[27], model[26]});
    ptr_sel = 2'd3; #1;
    chk("R6", ptr_rd_data, 16'h0000);
    rd_b_idx = 5'd28; #1;
    chk("R6", {8'h0, rd_b_data}, 16'h00EF);
    step();
    ptr_wr_en = 1; ptr_sel = 2'd3; ptr_wr_data = 16'h1234;
    step(); idle();
    check_all("R7");

    // R8: precedence
    ptr_wr_en = 1; ptr_sel = 2'd2; ptr_wr_data = 16'hA1B2;
    wr_en = 1; wr_idx = 5'd30; wr_data = 8'h55;
    ds_wr_en = 1; ds_addr = 16'h001F; ds_wdata = 8'h66;
    model[30] = 8'hB2; model[31] = 8'hA1;
    step(); idle();
    ptr_sel = 2'd2; #1;
    chk("R8", ptr_rd_data, 16'hA1B2);
    step();
    wr_en = 1; wr_idx = 5'd10; wr_data = 8'h10;
    ds_wr_en = 1; ds_addr = 16'h000A; ds_wdata = 8'h20; model[10] = 8'h10;
    step(); idle();
    rd_b_idx = 5'd10; #1;
    chk("R8", {8'h0, rd_b_data}, 16'h0010);
    step();

    // R12: three writers, distinct targets
    wr_en = 1; wr_idx = 5'd1; wr_data = 8'h01;
    ds_wr_en = 1; ds_addr = 16'h0002; ds_wdata = 8'h02;
    ptr_wr_en = 1; ptr_sel = 2'd0; ptr_wr_data = 16'h0403;
    model[1] = 8'h01; model[2] = 8'h02; model[26] = 8'h03; model[27] = 8'h04;
    step(); idle();
    check_all("R12");

    // R9: SRAM routing
    ds_rd_en = 1; ds_addr = 16'h0060; sram_rdata = 8'hC3; #1;
    chk("R9", {15'h0, sram_rd_en}, 16'h1);
    chk("R9", sram_addr, 16'h0060);
    chk("R9", {8'h0, ds_rdata}, 16'h00C3);
    idle(); ds_wr_en = 1; ds_addr = 16'h0FFF; ds_wdata = 8'h9E; #1;
    chk("R9", {15'h0, sram_wr_en}, 16'h1);
    chk("R9", {8'h0, sram_wdata}, 16'h009E);
    chk("R9", {14'h0, io_hit, oor_flag}, 16'h0);
    step(); idle();

    // R10: I/O window isolated
    ds_wr_en = 1; ds_addr = 16'h0040; ds_wdata = 8'h99; #1;
    chk("R10", {15'h0, io_hit}, 16'h1);
    chk("R10", {15'h0, sram_wr_en}, 16'h0);
    step(); idle();
    ds_rd_en = 1; ds_addr = 16'h005F; #1;
    chk("R10", {8'h0, ds_rdata}, 16'h0);
    chk("R10", {15'h0, io_hit}, 16'h1);
    ds_addr = 16'h0020; #1;
    chk("R10", {15'h0, io_hit}, 16'h1);
    step(); idle();
    check_all("R10");

    // R11: out of range
    ds_wr_en = 1; ds_addr = 16'h1000; ds_wdata = 8'h44; #1;
    chk("R11", {15'h0, oor_flag}, 16'h1);
    chk("R11", {15'h0, sram_wr_en}, 16'h0);
    step(); idle();
    ds_rd_en = 1; ds_addr = 16'hFFFF; #1;
    chk("R11", {8'h0, ds_rdata}, 16'h0);
    chk("R11", {14'h0, oor_flag, sram_rd_en}, 16'h2);
    step(); idle();
    check_all("R11");

    // R1: mid-run reset clears everything
    rst_n = 0;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    #1;
    ptr_sel = 2'd2; #1;
    chk("R1", ptr_rd_data, 16'h0);
    check_all("R1");
    rst_n = 1; step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule